// File: doc/BRIEF.md
# FIFO Threshold Offset Register Unit

This block stores the two thresholds that set a FIFO's almost-empty and almost-full flags, and it compares the FIFO's current fill count against them. Each threshold is a word count. The almost-empty threshold is measured up from the empty end, and the almost-full threshold is measured down from the full end. The FIFO storage and its pointers sit outside this block; the block only receives the fill count.

While the master reset is held, the level of the load strobe `ld` selects one of two setups:
- `ld` high: bit-serial loading, with both thresholds at the larger default.
- `ld` low: word-parallel loading, with both thresholds at the smaller default.

Loading always fills the almost-empty threshold first and the almost-full threshold second, then starts over. Either threshold can be read back on the read clock, in the same order, whichever loading method is active. A partial reset restarts all sequences but keeps the thresholds and the loading method.

Top module: `flag_ofs_top`

## Requirements
- R1: If `mst_rst` is high at a `wclk` edge, the unit takes the setup chosen by `ld` at that edge. With `ld`=1 it uses serial loading and sets both thresholds to `DEF_SER` (1023). With `ld`=0 it uses parallel loading and sets both thresholds to `DEF_PAR` (127). The loading method changes only under master reset.
- R2: If `prt_rst` is high at an edge (and `mst_rst` is low), both thresholds and the loading method keep their values. The load order, the serial bit position and the readback order all restart at the almost-empty threshold.
- R3: In parallel mode, a `wclk` edge with `ld`=1 and `wr_en`=1 copies `wr_data` into one threshold. Successive writes go to almost-empty, then almost-full, then almost-empty again.
- R4: In serial mode, a `wclk` edge with `ld`=1 and `ser_en`=1 stores `ser_in` as one bit of a threshold. Bits arrive LSB first: the k-th bit goes to bit k. After OW bits the next bit goes to bit 0 of the other threshold, and after almost-full the sequence returns to almost-empty.
- R5: Some strobes leave both thresholds unchanged:
  - serial strobes in parallel mode;
  - parallel strobes in serial mode;
  - any strobe with `ld`=0.
- R6: A `rclk` edge with `ld`=1 and `rd_en`=1 puts a threshold on `rd_data`. Successive readbacks return almost-empty, then almost-full, alternating, in either loading mode. `rd_data` holds its value between readbacks.
- R7: `almost_empty` is 1 exactly when `fill_cnt` is less than or equal to the almost-empty threshold.
- R8: `almost_full` is 1 exactly when the free space, 2^AW − `fill_cnt`, is less than or equal to the almost-full threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; all loading happens on its rising edge |
| rclk | input | 1 | Read clock; readback happens on its rising edge |
| mst_rst | input | 1 | Synchronous master reset, active high, sampled on both clocks |
| prt_rst | input | 1 | Synchronous partial reset, active high, sampled on both clocks |
| ld | input | 1 | Load/readback strobe; also selects the setup during master reset |
| ser_en | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial data bit |
| wr_en | input | 1 | Parallel load enable |
| wr_data | input | OW | Parallel threshold word |
| rd_en | input | 1 | Readback enable |
| rd_data | output | OW | Readback threshold word (registered on rclk) |
| fill_cnt | input | AW+1 | Words currently stored in the FIFO |
| almost_empty | output | 1 | Fill count at or below the almost-empty threshold |
| almost_full | output | 1 | Free space at or below the almost-full threshold |

## Verification
The flag comparisons are exercised with a table of fill counts. The table sits on either side of both thresholds, at the empty and full limits, and in the middle. This distinguishes an off-by-one or strict comparison from the inclusive one required. Serial loading is exercised with asymmetric patterns such as 0x1234 and 0x0F0F, which reveal a reversed bit order or a missed switch between thresholds. Strobes of the wrong kind are sent in each mode to check that they are ignored. Interrupted serial and parallel sequences are followed by a partial reset to show that the load order restarts while the stored values survive.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/ofs_load_unit.sv
module ofs_load_unit
    import flag_ofs_pkg::*;
#(
    parameter int OW      = 16,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic          clk,
    input  logic          mst_rst,
    input  logic          prt_rst,
    input  logic          ld,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_data,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off,
    output load_mode_e    mode
);
    localparam int BW = (OW > 1) ? $clog2(OW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(OW - 1);

    typedef struct packed {
        load_mode_e    mode;
        ofs_sel_e      sel;
        logic [BW-1:0] bitpos;
        logic [OW-1:0] ae;
        logic [OW-1:0] af;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mst_rst) begin
            st_d.mode   = ld ? LOAD_SER : LOAD_PAR;
            st_d.ae     = ld ? OW'(DEF_SER) : OW'(DEF_PAR);
            st_d.af     = ld ? OW'(DEF_SER) : OW'(DEF_PAR);
            st_d.sel    = SEL_AE;
            st_d.bitpos = '0;
        end else if (prt_rst) begin
            st_d.sel    = SEL_AE;
            st_d.bitpos = '0;
        end else if (ld) begin
            if (st_q.mode == LOAD_PAR && wr_en) begin
                if (st_q.sel == SEL_AE) st_d.ae = wr_data;
                else                    st_d.af = wr_data;
                st_d.sel = (st_q.sel == SEL_AE) ? SEL_AF : SEL_AE;
            end else if (st_q.mode == LOAD_SER && ser_en) begin
                if (st_q.sel == SEL_AE) st_d.ae[st_q.bitpos] = ser_in;
                else                    st_d.af[st_q.bitpos] = ser_in;
                if (st_q.bitpos == LAST_BIT) begin
                    st_d.bitpos = '0;
                    st_d.sel    = (st_q.sel == SEL_AE) ? SEL_AF : SEL_AE;
                end else begin
                    st_d.bitpos = st_q.bitpos + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ae_off = st_q.ae;
    assign af_off = st_q.af;
    assign mode   = st_q.mode;

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import flag_ofs_pkg::*;
#(
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          mst_rst,
    input  logic          prt_rst,
    input  logic          ld,
    input  logic          rd_en,
    input  logic [OW-1:0] ae_off,
    input  logic [OW-1:0] af_off,
    output logic [OW-1:0] rd_data
);
    typedef struct packed {
        ofs_sel_e      sel;
        logic [OW-1:0] data;
    } rb_state_t;

    rb_state_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (mst_rst) begin
            rb_d.sel  = SEL_AE;
            rb_d.data = '0;
        end else if (prt_rst) begin
            rb_d.sel = SEL_AE;
        end else if (ld && rd_en) begin
            rb_d.data = (rb_q.sel == SEL_AE) ? ae_off : af_off;
            rb_d.sel  = (rb_q.sel == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    always_ff @(posedge clk) begin
        rb_q <= rb_d;
    end

    assign rd_data = rb_q.data;

endmodule

// File: rtl/ofs_threshold.sv
module ofs_threshold #(
    parameter int AW        = 16,
    parameter int OW        = 16,
    parameter bit FULL_SIDE = 1'b0
) (
    input  logic [AW:0]   fill_cnt,
    input  logic [OW-1:0] offset,
    output logic          flag
);
    localparam int CW = ((AW + 2) > OW) ? (AW + 2) : OW;
    localparam logic [CW-1:0] DEPTH_C = CW'(1) << AW;

    logic [CW-1:0] level;

    generate
        if (FULL_SIDE) begin : g_free
            assign level = DEPTH_C - CW'(fill_cnt);
        end else begin : g_used
            assign level = CW'(fill_cnt);
        end
    endgenerate

    assign flag = (level <= CW'(offset));

endmodule

// File: rtl/flag_ofs_top.sv
module flag_ofs_top
    import flag_ofs_pkg::*;
#(
    parameter int AW      = 16,
    parameter int OW      = 16,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mst_rst,
    input  logic          prt_rst,
    input  logic          ld,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_data,
    input  logic          rd_en,
    output logic [OW-1:0] rd_data,
    input  logic [AW:0]   fill_cnt,
    output logic          almost_empty,
    output logic          almost_full
);
    logic [OW-1:0] ae_off_w;
    logic [OW-1:0] af_off_w;
    load_mode_e    mode_w;

    ofs_load_unit #(
        .OW(OW), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
    ) u_load (
        .clk(wclk), .mst_rst(mst_rst), .prt_rst(prt_rst), .ld(ld),
        .ser_en(ser_en), .ser_in(ser_in), .wr_en(wr_en), .wr_data(wr_data),
        .ae_off(ae_off_w), .af_off(af_off_w), .mode(mode_w)
    );

    ofs_readback #(.OW(OW)) u_rb (
        .clk(rclk), .mst_rst(mst_rst), .prt_rst(prt_rst), .ld(ld),
        .rd_en(rd_en), .ae_off(ae_off_w), .af_off(af_off_w),
        .rd_data(rd_data)
    );

    ofs_threshold #(.AW(AW), .OW(OW), .FULL_SIDE(1'b0)) u_ae (
        .fill_cnt(fill_cnt), .offset(ae_off_w), .flag(almost_empty)
    );

    ofs_threshold #(.AW(AW), .OW(OW), .FULL_SIDE(1'b1)) u_af (
        .fill_cnt(fill_cnt), .offset(af_off_w), .flag(almost_full)
    );

endmodule

// File: rtl/flag_ofs_chk.sv
module flag_ofs_chk
    import flag_ofs_pkg::*;
#(
    parameter int OW      = 16,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input logic          wclk,
    input logic          mst_rst,
    input logic          prt_rst,
    input logic          ld,
    input logic          ser_en,
    input logic          wr_en,
    input logic [OW-1:0] ae_off,
    input logic [OW-1:0] af_off,
    input load_mode_e    mode
);
    assert_reset_default_R1: assert property (@(posedge wclk)
        mst_rst |=> (ae_off == ($past(ld) ? OW'(DEF_SER) : OW'(DEF_PAR)))
                 && (af_off == ($past(ld) ? OW'(DEF_SER) : OW'(DEF_PAR)))
                 && (mode == ($past(ld) ? LOAD_SER : LOAD_PAR)));

    assert_mode_held_R1: assert property (@(posedge wclk) disable iff (mst_rst)
        !mst_rst |=> $stable(mode));

    assert_partial_keeps_R2: assert property (@(posedge wclk) disable iff (mst_rst)
        prt_rst |=> $stable(ae_off) && $stable(af_off));

    assert_par_one_reg_R3: assert property (@(posedge wclk) disable iff (mst_rst)
        (mode == LOAD_PAR && ld && wr_en && !prt_rst) |=> ($stable(ae_off) || $stable(af_off)));

    assert_ser_one_bit_R4: assert property (@(posedge wclk) disable iff (mst_rst)
        (mode == LOAD_SER && ld && ser_en && !prt_rst)
            |=> ($countones({ae_off, af_off} ^ $past({ae_off, af_off})) <= 1));

    assert_no_ld_R5: assert property (@(posedge wclk) disable iff (mst_rst)
        !ld |=> $stable(ae_off) && $stable(af_off));

    assert_par_ignores_ser_R5: assert property (@(posedge wclk) disable iff (mst_rst)
        (mode == LOAD_PAR && !wr_en) |=> $stable(ae_off) && $stable(af_off));

    assert_ser_ignores_par_R5: assert property (@(posedge wclk) disable iff (mst_rst)
        (mode == LOAD_SER && !ser_en) |=> $stable(ae_off) && $stable(af_off));

endmodule

bind flag_ofs_top flag_ofs_chk #(
    .OW(OW), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
) u_chk (
    .wclk(wclk), .mst_rst(mst_rst), .prt_rst(prt_rst), .ld(ld),
    .ser_en(ser_en), .wr_en(wr_en), .ae_off(ae_off_w), .af_off(af_off_w),
    .mode(mode_w)
);

// File: tb/sim_flag_ofs_top.sv
module sim_flag_ofs_top;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int AW = 16;
    localparam int OW = 16;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mst_rst = 1'b1;
    logic          prt_rst = 1'b0;
    logic          ld = 1'b0;
    logic          ser_en = 1'b0;
    logic          ser_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [OW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [OW-1:0] rd_data;
    logic [AW:0]   fill_cnt = '0;
    logic          almost_empty;
    logic          almost_full;

    int n_chk = 0;
    int n_bad = 0;

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    flag_ofs_top #(.AW(AW), .OW(OW)) u0 (
        .wclk(wclk), .rclk(rclk), .mst_rst(mst_rst), .prt_rst(prt_rst),
        .ld(ld), .ser_en(ser_en), .ser_in(ser_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .fill_cnt(fill_cnt), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // entry: {fill count, expected almost_empty, expected almost_full}
    // thresholds in force: almost-empty 100, almost-full 200
    localparam logic [18:0] VEC [0:8] = '{
        {17'd0,     1'b1, 1'b0},
        {17'd99,    1'b1, 1'b0},
        {17'd100,   1'b1, 1'b0},
        {17'd101,   1'b0, 1'b0},
        {17'd50000, 1'b0, 1'b0},
        {17'd65335, 1'b0, 1'b0},
        {17'd65336, 1'b0, 1'b1},
        {17'd65400, 1'b0, 1'b1},
        {17'd65536, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_reset(input logic master, input logic ld_lvl);
        @(negedge wclk);
        if (master) mst_rst = 1'b1; else prt_rst = 1'b1;
        ld = ld_lvl;
        repeat (4) @(negedge wclk);
        mst_rst = 1'b0;
        prt_rst = 1'b0;
        ld = 1'b0;
        repeat (2) @(negedge wclk);
    endtask

    task automatic wr_par(input logic [OW-1:0] v);
        @(negedge wclk);
        ld = 1'b1; wr_en = 1'b1; wr_data = v;
        @(negedge wclk);
        ld = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr_ser(input logic [OW-1:0] v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge wclk);
            ld = 1'b1; ser_en = 1'b1; ser_in = v[i];
        end
        @(negedge wclk);
        ld = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
    endtask

    task automatic rd_pair(output logic [OW-1:0] a, output logic [OW-1:0] b);
        @(negedge rclk);
        ld = 1'b1; rd_en = 1'b1;
        @(negedge rclk);
        a = rd_data;
        @(negedge rclk);
        b = rd_data;
        ld = 1'b0; rd_en = 1'b0;
        @(negedge wclk);
    endtask

    task automatic check_flags(input string req, input int fill, input logic e_ae, input logic e_af);
        fill_cnt = (AW+1)'(fill);
        #1;
        chk(req, $sformatf("almost_empty at fill %0d", fill), int'(almost_empty), int'(e_ae));
        chk(req, $sformatf("almost_full at fill %0d", fill), int'(almost_full), int'(e_af));
    endtask

    initial begin : watchdog
        #(WCLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [OW-1:0] a, b;

        // R1: master reset with ld low -> parallel mode, both thresholds 127
        do_reset(1'b1, 1'b0);
        rd_pair(a, b);
        chk("R1", "ae default parallel", int'(a), 127);
        chk("R1", "af default parallel", int'(b), 127);
        chk("R6", "rd_data holds", int'(rd_data), 127);
        check_flags("R7", 127, 1'b1, 1'b0);
        check_flags("R7", 128, 1'b0, 1'b0);

        // R3: parallel loads, almost-empty first
        wr_par(16'd100);
        wr_par(16'd200);
        rd_pair(a, b);
        chk("R3", "ae parallel", int'(a), 100);
        chk("R3", "af parallel", int'(b), 200);

        // R7, R8: vector table walk
        for (int i = 0; i < 9; i++) begin
            check_flags("R7/R8", int'(VEC[i][18:2]), VEC[i][1], VEC[i][0]);
        end

        // R5: serial strobes ignored in parallel mode
        wr_ser(16'hFFFF, 16);
        rd_pair(a, b);
        chk("R5", "ae after serial in parallel mode", int'(a), 100);
        chk("R5", "af after serial in parallel mode", int'(b), 200);
        check_flags("R5", 100, 1'b1, 1'b0);

        // R2: partial reset mid-sequence restarts order, keeps values
        wr_par(16'd300);
        do_reset(1'b0, 1'b0);
        rd_pair(a, b);
        chk("R2", "ae kept after partial", int'(a), 300);
        chk("R2", "af kept after partial", int'(b), 200);
        wr_par(16'd400);
        rd_pair(a, b);
        chk("R2", "load restarts at ae", int'(a), 400);
        chk("R2", "af untouched", int'(b), 200);

        // R3: wrap back to almost-empty after almost-full
        wr_par(16'd500);
        wr_par(16'd600);
        rd_pair(a, b);
        chk("R3", "wrap ae", int'(a), 600);
        chk("R3", "af second", int'(b), 500);

        // R1: master reset with ld high -> serial mode, 1023
        do_reset(1'b1, 1'b1);
        rd_pair(a, b);
        chk("R1", "ae default serial", int'(a), 1023);
        chk("R1", "af default serial", int'(b), 1023);
        check_flags("R7", 1023, 1'b1, 1'b0);
        check_flags("R7", 1024, 1'b0, 1'b0);
        check_flags("R8", 64513, 1'b0, 1'b1);
        check_flags("R8", 64512, 1'b0, 1'b0);

        // R5: parallel strobe ignored in serial mode
        wr_par(16'd55);
        rd_pair(a, b);
        chk("R5", "ae after parallel in serial mode", int'(a), 1023);
        chk("R5", "af after parallel in serial mode", int'(b), 1023);

        // R4: serial load LSB first, then the other threshold
        wr_ser(16'h1234, 16);
        wr_ser(16'h0F0F, 16);
        rd_pair(a, b);
        chk("R4", "ae serial", int'(a), 32'h1234);
        chk("R4", "af serial", int'(b), 32'h0F0F);

        // R4: wrap, 17th bit goes to almost-empty bit 0 next cycle of pairs
        wr_ser(16'h00FF, 16);
        rd_pair(a, b);
        chk("R4", "ae after wrap", int'(a), 32'h00FF);

        // R2: partial reset resets serial bit position
        wr_ser(16'h000F, 4);
        do_reset(1'b0, 1'b0);
        wr_ser(16'hABCD, 16);
        rd_pair(a, b);
        chk("R2", "serial restart ae", int'(a), 32'hABCD);
        chk("R2", "serial restart af", int'(b), 32'h0F0F);

        fill_cnt = '0;
        repeat (2) @(negedge wclk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule